// File: doc/BRIEF.md
# DDR Burst Read Return Aligner

This block is the host-side read path for a synchronous SRAM that returns a four-beat burst at double data rate. The host makes a read request with an address. The block places the request in the read command slot of the memory bus. Because a burst holds the return bus for two full cycles, a new command may be placed at most every other cycle.

Returned data is modelled as one rising-edge beat and one falling-edge beat per clock cycle. The first pair arrives a fixed number of cycles after the command and the second pair arrives one cycle after that. A small pipeline of issued-command records tells the block in which cycles data is due. The block captures both pairs, checks them against the memory's data-valid flag and packs the four beats into one response word. The response carries the address of the command that produced it. A data-valid flag that shows up when no data is due is reported on a separate pulse output.

Top module: `ddr_rd_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_rd_cmd, rsp_valid, rsp_err and rsp_orphan are 0 and req_ready is 1.
- R2: A request is accepted when req_valid and req_ready are both 1 in a cycle, and mem_rd_cmd is then 1 with mem_rd_addr equal to req_addr in the next cycle. req_ready is 0 in every cycle in which mem_rd_cmd is 1. A request made while req_ready is 0 is ignored and issues no command.
- R3: For a command on the bus in cycle c, the first beat pair is taken from mem_q_rise and mem_q_fall in cycle c+LAT, and the second pair is taken in cycle c+LAT+1 (LAT defaults to 2).
- R4: rsp_valid is 1 for exactly the single cycle c+LAT+2 for each command issued in cycle c, and is 0 in every other cycle.
- R5: rsp_data holds beat 1 (first rising) in bits [DW-1:0], beat 2 (first falling) in [2DW-1:DW], beat 3 (second rising) in [3DW-1:2DW] and beat 4 (second falling) in [4DW-1:3DW].
- R6: rsp_addr equals the mem_rd_addr of the command that the response answers.
- R7: rsp_err is 1 with a response exactly when mem_dvld was 0 in either of the two cycles in which that burst's data was due.
- R8: rsp_orphan is 1 for one cycle, one cycle after any cycle in which mem_dvld is 1 while no burst data is due. It is 0 otherwise.
- R9: Commands issued every other cycle each produce their own response, in order, every other cycle, with no beats mixed between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | AW | Host read address |
| req_ready | output | 1 | Command slot free this cycle |
| mem_rd_cmd | output | 1 | Read command to the memory |
| mem_rd_addr | output | AW | Read address to the memory |
| mem_dvld | input | 1 | Memory data-valid flag for this cycle's beat pair |
| mem_q_rise | input | DW | Beat captured on the rising edge |
| mem_q_fall | input | DW | Beat captured on the falling edge |
| rsp_valid | output | 1 | Response word valid |
| rsp_addr | output | AW | Address of the answered command |
| rsp_data | output | 4*DW | Packed burst, beat 1 lowest |
| rsp_err | output | 1 | Data-valid missing during the burst |
| rsp_orphan | output | 1 | Data-valid seen with nothing outstanding |

## Verification
The bench drives its inputs at the falling edge and reads outputs at the next falling edge. A command therefore shows up one cycle after the request is accepted, a response one cycle after the second beat pair, and an orphan pulse one cycle after the stray data-valid flag. A model memory keeps a short history of the commands seen on the bus. It drives the first pair LAT cycles after a command and the second pair one cycle later. From the same history it sets the expected response for the following cycle. Every cycle it compares the command, ready, response and orphan outputs against these expected values, so any shift in latency by even one cycle is reported.

// File: rtl/rla_pkg.sv
package rla_pkg;

    localparam int BURST_BEATS = 4;
    localparam int BEATS_PER_CYCLE = 2;
    localparam int CYCLES_PER_BURST = BURST_BEATS / BEATS_PER_CYCLE;

    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_BOTH   = 2'd3
    } phase_e;

    function automatic phase_e classify(input logic first_due, input logic second_due);
        phase_e ph;
        case ({second_due, first_due})
            2'b01:   ph = PH_FIRST;
            2'b10:   ph = PH_SECOND;
            2'b11:   ph = PH_BOTH;
            default: ph = PH_NONE;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/rla_issue.sv
module rla_issue #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          cmd,
    output logic [AW-1:0] cmd_addr
);
    logic accept;

    // a burst holds the return bus for two cycles, so the slot is blocked right after a command
    assign req_ready = !cmd;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= 1'b0;
            cmd_addr <= '0;
        end else begin
            cmd <= accept;
            if (accept) begin
                cmd_addr <= req_addr;
            end
        end
    end
endmodule

// File: rtl/rla_tag_pipe.sv
module rla_tag_pipe
    import rla_pkg::*;
#(
    parameter int AW  = 8,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd,
    input  logic [AW-1:0] cmd_addr,
    output phase_e        phase,
    output logic [AW-1:0] tag_addr
);
    localparam int DEPTH = LAT + 1;

    logic [DEPTH-1:0] vld_q;
    logic [AW-1:0]    addr_q [DEPTH];

    // stage k holds the command issued k+1 cycles ago
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                addr_q[k] <= '0;
            end
        end else begin
            vld_q[0]  <= cmd;
            addr_q[0] <= cmd_addr;
            for (int k = 1; k < DEPTH; k++) begin
                vld_q[k]  <= vld_q[k-1];
                addr_q[k] <= addr_q[k-1];
            end
        end
    end

    assign phase    = classify(vld_q[LAT-1], vld_q[LAT]);
    assign tag_addr = addr_q[LAT];
endmodule

// File: rtl/rla_assemble.sv
module rla_assemble
    import rla_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  phase_e                     phase,
    input  logic [AW-1:0]              tag_addr,
    input  logic                       dvld,
    input  logic [DW-1:0]              q_rise,
    input  logic [DW-1:0]              q_fall,
    output logic                       rsp_valid,
    output logic [AW-1:0]              rsp_addr,
    output logic [BURST_BEATS*DW-1:0]  rsp_data,
    output logic                       rsp_err,
    output logic                       rsp_orphan
);
    logic [DW-1:0] head_rise;
    logic [DW-1:0] head_fall;
    logic          head_miss;
    logic [DW-1:0] word_q [BURST_BEATS];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_rise  <= '0;
            head_fall  <= '0;
            head_miss  <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_err    <= 1'b0;
            rsp_orphan <= 1'b0;
            for (int b = 0; b < BURST_BEATS; b++) begin
                word_q[b] <= '0;
            end
        end else begin
            rsp_valid  <= 1'b0;
            rsp_orphan <= 1'b0;
            case (phase)
                PH_FIRST: begin
                    head_rise <= q_rise;
                    head_fall <= q_fall;
                    head_miss <= !dvld;
                end
                PH_SECOND: begin
                    word_q[0] <= head_rise;
                    word_q[1] <= head_fall;
                    word_q[2] <= q_rise;
                    word_q[3] <= q_fall;
                    rsp_valid <= 1'b1;
                    rsp_addr  <= tag_addr;
                    rsp_err   <= head_miss || !dvld;
                end
                PH_NONE: begin
                    rsp_orphan <= dvld;
                end
                default: begin
                    rsp_err <= 1'b1;
                end
            endcase
        end
    end

    for (genvar g = 0; g < BURST_BEATS; g++) begin : g_pack
        assign rsp_data[g*DW +: DW] = word_q[g];
    end
endmodule

// File: rtl/ddr_rd_aligner.sv
module ddr_rd_aligner
    import rla_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int LAT = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_addr,
    output logic                      req_ready,
    output logic                      mem_rd_cmd,
    output logic [AW-1:0]             mem_rd_addr,
    input  logic                      mem_dvld,
    input  logic [DW-1:0]             mem_q_rise,
    input  logic [DW-1:0]             mem_q_fall,
    output logic                      rsp_valid,
    output logic [AW-1:0]             rsp_addr,
    output logic [BURST_BEATS*DW-1:0] rsp_data,
    output logic                      rsp_err,
    output logic                      rsp_orphan
);
    phase_e        phase;
    logic [AW-1:0] tag_addr;

    rla_issue #(.AW(AW)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .cmd       (mem_rd_cmd),
        .cmd_addr  (mem_rd_addr)
    );

    rla_tag_pipe #(.AW(AW), .LAT(LAT)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .cmd      (mem_rd_cmd),
        .cmd_addr (mem_rd_addr),
        .phase    (phase),
        .tag_addr (tag_addr)
    );

    rla_assemble #(.AW(AW), .DW(DW)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .tag_addr   (tag_addr),
        .dvld       (mem_dvld),
        .q_rise     (mem_q_rise),
        .q_fall     (mem_q_fall),
        .rsp_valid  (rsp_valid),
        .rsp_addr   (rsp_addr),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .rsp_orphan (rsp_orphan)
    );
endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
    parameter int LAT = 2
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic mem_rd_cmd,
    input logic mem_dvld,
    input logic rsp_valid,
    input logic rsp_err,
    input logic rsp_orphan
);
    // hist[k] = command on the bus k+1 cycles ago
    logic [LAT+2:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[LAT+1:0], mem_rd_cmd};
        end
    end

    p_cmd_gap_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_cmd |=> !mem_rd_cmd);

    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> !mem_rd_cmd);

    p_rsp_due_r4: assert property (@(posedge clk) disable iff (rst)
        hist[LAT+1] |-> rsp_valid);

    p_rsp_only_when_due_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> hist[LAT+1]);

    p_clean_needs_dvld_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> ($past(mem_dvld) && $past(mem_dvld, 2)));

    p_orphan_source_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_orphan |-> ($past(mem_dvld) && !hist[LAT] && !hist[LAT+1]));

    p_no_orphan_with_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        !(rsp_orphan && rsp_valid));
endmodule

bind ddr_rd_aligner rla_checker #(.LAT(LAT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_rd_cmd (mem_rd_cmd),
    .mem_dvld   (mem_dvld),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_orphan (rsp_orphan)
);

// File: tb/sim_ddr_rd_aligner.sv
module sim_ddr_rd_aligner;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int LAT = 2;
    localparam int HD  = LAT + 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [AW-1:0]     req_addr;
    logic              req_ready;
    logic              mem_rd_cmd;
    logic [AW-1:0]     mem_rd_addr;
    logic              mem_dvld;
    logic [DW-1:0]     mem_q_rise;
    logic [DW-1:0]     mem_q_fall;
    logic              rsp_valid;
    logic [AW-1:0]     rsp_addr;
    logic [4*DW-1:0]   rsp_data;
    logic              rsp_err;
    logic              rsp_orphan;

    always #10 clk = ~clk;

    ddr_rd_aligner #(.AW(AW), .DW(DW), .LAT(LAT)) u0 (.*);

    int checks = 0;
    int fails  = 0;

    logic          h_cmd  [HD];
    logic [AW-1:0] h_addr [HD];
    logic          exp_cmd, exp_rsp, exp_err, exp_orph, drop_first;
    logic [AW-1:0] exp_addr, exp_raddr;
    logic [4*DW-1:0] exp_data;

    function automatic logic [DW-1:0] beat_val(input logic [AW-1:0] a, input int k);
        return (DW'(a) * DW'(37)) ^ DW'(16'h5A3C) ^ DW'(k * 16'h1111);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one bench cycle: check last cycle's expectations, then drive this cycle
    task automatic step(input bit rv, input logic [AW-1:0] ra, input int drop_pct,
                        input int spur_pct, input bit f_d1, input bit f_d2);
        logic d;
        @(negedge clk);
        chk(mem_rd_cmd == exp_cmd, "R2 command", 64'(mem_rd_cmd), 64'(exp_cmd));
        if (exp_cmd) chk(mem_rd_addr == exp_addr, "R2 address", 64'(mem_rd_addr), 64'(exp_addr));
        chk(req_ready == !exp_cmd, "R2 ready", 64'(req_ready), 64'(!exp_cmd));
        chk(rsp_valid == exp_rsp, "R4 R9 response valid", 64'(rsp_valid), 64'(exp_rsp));
        if (exp_rsp) begin
            chk(rsp_addr == exp_raddr, "R6 response address", 64'(rsp_addr), 64'(exp_raddr));
            chk(rsp_err == exp_err, "R7 error flag", 64'(rsp_err), 64'(exp_err));
            if (!exp_err) chk(rsp_data == exp_data, "R3 R5 data", 64'(rsp_data), 64'(exp_data));
        end
        chk(rsp_orphan == exp_orph, "R8 orphan", 64'(rsp_orphan), 64'(exp_orph));

        for (int i = HD-1; i > 0; i--) begin
            h_cmd[i]  = h_cmd[i-1];
            h_addr[i] = h_addr[i-1];
        end
        h_cmd[0]  = mem_rd_cmd;
        h_addr[0] = mem_rd_addr;

        exp_rsp  = 1'b0;
        exp_orph = 1'b0;
        if (h_cmd[LAT]) begin
            d = !(f_d1 || (int'($urandom % 100) < drop_pct));
            drop_first = !d;
            mem_dvld   = d;
            mem_q_rise = beat_val(h_addr[LAT], 0);
            mem_q_fall = beat_val(h_addr[LAT], 1);
        end else if (h_cmd[LAT+1]) begin
            d = !(f_d2 || (int'($urandom % 100) < drop_pct));
            mem_dvld   = d;
            mem_q_rise = beat_val(h_addr[LAT+1], 2);
            mem_q_fall = beat_val(h_addr[LAT+1], 3);
            exp_rsp    = 1'b1;
            exp_raddr  = h_addr[LAT+1];
            exp_err    = drop_first || !d;
            exp_data   = {beat_val(h_addr[LAT+1], 3), beat_val(h_addr[LAT+1], 2),
                          beat_val(h_addr[LAT+1], 1), beat_val(h_addr[LAT+1], 0)};
        end else begin
            d = (int'($urandom % 100) < spur_pct);
            mem_dvld   = d;
            exp_orph   = d;
            mem_q_rise = DW'($urandom);
            mem_q_fall = DW'($urandom);
        end

        exp_cmd = rv && !mem_rd_cmd;
        if (exp_cmd) exp_addr = ra;
        req_valid = rv;
        req_addr  = ra;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < HD; i++) begin
            h_cmd[i]  = 1'b0;
            h_addr[i] = '0;
        end
        exp_cmd = 0; exp_rsp = 0; exp_err = 0; exp_orph = 0; drop_first = 0;
        exp_addr = '0; exp_raddr = '0; exp_data = '0;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        mem_dvld = 1'b0; mem_q_rise = '0; mem_q_fall = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_rd_cmd == 1'b0, "R1 command idle", 64'(mem_rd_cmd), 64'd0);
        chk(rsp_valid == 1'b0, "R1 response idle", 64'(rsp_valid), 64'd0);
        chk(rsp_err == 1'b0, "R1 error idle", 64'(rsp_err), 64'd0);
        chk(rsp_orphan == 1'b0, "R1 orphan idle", 64'(rsp_orphan), 64'd0);
        chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        rst = 1'b0;

        // R9 back-to-back: request held high, every other cycle accepted
        for (int i = 0; i < 24; i++) step(1'b1, AW'(8'h10 + i), 0, 0, 0, 0);
        for (int i = 0; i < 6; i++)  step(1'b0, '0, 0, 0, 0, 0);

        // R7 data-valid missing on the first pair only, then on the second only
        step(1'b1, AW'(8'hA1), 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, '0, 0, 0, 1, 0);
        step(1'b1, AW'(8'hB2), 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1'b0, '0, 0, 0, 0, 1);

        // R8 stray data-valid while idle
        for (int i = 0; i < 8; i++) step(1'b0, '0, 0, 100, 0, 0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 0, 0, 0, 0);

        // mixed random traffic with faults
        for (int i = 0; i < 4000; i++)
            step(1'($urandom % 2), AW'($urandom), 6, 6, 0, 0);
        for (int i = 0; i < 8; i++) step(1'b0, '0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule